// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence for one burst of a synchronous DRAM column access. A start strobe loads a starting column, a 3-bit length code and an ordering bit. From the next clock the block emits one column address per beat, together with a valid flag and a flag that marks the final beat. Addresses follow either a wrap-around ascending order or an XOR-interleaved order inside the aligned block that the burst length defines. A separate full-row mode runs through all 256 columns and wraps around until it is stopped.

The address stream is a valid/ready output. A beat is consumed on a clock edge where both `col_valid_o` and `col_ready_i` are high. While ready is low, the current address and its last flag hold, and no beat is lost. The control inputs are not subject to back-pressure. A start strobe always truncates the running burst and begins the new one on the next cycle, so column commands can be spaced one clock apart. A stop input ends the burst at once. If a length code is reserved, the block pulses an error flag and emits nothing.

Top module: `burst_col_gen`

## Requirements
- R1: Length code 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. `col_valid_o` stays high for exactly that many consumed beats and then falls.
- R2: With `ilv_i`=0 the beat n address is (start+n) modulo the block size in the low bits. The bits above the block keep the starting value. For example, start 1 with 4 beats gives 1,2,3,0.
- R3: With `ilv_i`=1 the beat n address is start XOR n. For example, start 5 with 8 beats gives 5,4,7,6,1,0,3,2.
- R4: Code 111 with `ilv_i`=0 is a full-row burst. Beat n is (start+n) mod 256, wrapping from 255 to 0. It runs until a stop or a new start.
- R5: Codes 100, 101 and 110, and code 111 with `ilv_i`=1, are reserved. A start with a reserved code raises `err_o` for exactly one cycle, on the cycle after the start. It produces no valid beat and ends any burst in progress.
- R6: The first beat, equal to the start column, is valid on the cycle after a legal start. A start during an active burst truncates that burst, with the new first beat on the next cycle. Start has priority over stop on the same cycle.
- R7: A stop sampled with no start makes `col_valid_o` low from the next cycle.
- R8: `col_last_o` is high only on the final beat of a fixed-length burst and never in full-row mode.
- R9: While `col_valid_o` is high and `col_ready_i` is low, `col_o`, `col_last_o` and `col_valid_o` hold.
- R10: During reset `col_valid_o`, `col_last_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst with the inputs below |
| start_col_i | input | 8 | Starting column |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 0 ascending wrap order, 1 XOR-interleaved order |
| stop_i | input | 1 | End the current burst |
| col_ready_i | input | 1 | Consumer accepts the current beat |
| col_o | output | 8 | Column address of the current beat |
| col_valid_o | output | 1 | `col_o` holds a beat |
| col_last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | One-cycle pulse after a start with a reserved code |

## Verification
The bench sweeps every starting column with every fixed length in both orders. A design that let a carry leak above the aligned block, or that added instead of XORing, would emit a wrong column mid-burst. Full-row mode starts near the top of the row so the wrap from 255 to 0 is crossed, and any last flag there counts as an error. The bench also covers a truncating restart, a start and a stop on the same cycle, a stop in mid-burst, and reserved codes issued both idle and mid-burst. These catch wrong priority, a missed truncation, and an error case that still emits beats. Back-pressure stalls check that a held beat neither advances nor drops.

// File: rtl/bcg_pkg.sv
`timescale 1ns/1ps
package bcg_pkg;
  localparam int unsigned LEN_CODE_W = 3;

  typedef enum logic [LEN_CODE_W-1:0] {
    BL_ONE   = 3'b000,
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011,
    BL_ROW   = 3'b111
  } blen_e;
endpackage

// File: rtl/bcg_len_decode.sv
`timescale 1ns/1ps
module bcg_len_decode
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] code_i,
  input  logic                  ilv_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  full_o,
  output logic                  rsvd_o
);
  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    rsvd_o = 1'b0;
    case (code_i)
      BL_ONE, BL_TWO, BL_FOUR, BL_EIGHT:
        mask_o = COL_W'((32'd1 << code_i) - 32'd1);
      BL_ROW: begin
        if (ilv_i) begin
          rsvd_o = 1'b1;
        end else begin
          full_o = 1'b1;
          mask_o = '1;
        end
      end
      default: rsvd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/bcg_addr_map.sv
`timescale 1ns/1ps
module bcg_addr_map #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + idx_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? (ilv_i ? (base_i[b] ^ idx_i[b]) : sum[b])
                                : base_i[b];
  end
endmodule

// File: rtl/bcg_beat_ctr.sv
`timescale 1ns/1ps
module bcg_beat_ctr #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             kill_i,
  input  logic             take_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] idx_o,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             ilv_o
);
  logic             active_q, full_q, ilv_q;
  logic [COL_W-1:0] base_q, idx_q, mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
      mask_q   <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      full_q   <= full_i;
      ilv_q    <= ilv_i;
      base_q   <= base_i;
      idx_q    <= '0;
      mask_q   <= mask_i;
    end else if (kill_i) begin
      active_q <= 1'b0;
    end else if (active_q && take_i) begin
      idx_q <= idx_q + 1'b1;
      if (!full_q && (idx_q == mask_q)) active_q <= 1'b0;
    end
  end

  assign last_o   = active_q && !full_q && (idx_q == mask_q);
  assign active_o = active_q;
  assign base_o   = base_q;
  assign idx_o    = idx_q;
  assign mask_o   = mask_q;
  assign full_o   = full_q;
  assign ilv_o    = ilv_q;

  // R1
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && take_i && !load_i |=> !active_q);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !take_i && !load_i && !kill_i |=> active_q && $stable(idx_q));
endmodule

// File: rtl/burst_col_gen.sv
`timescale 1ns/1ps
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  ilv_i,
  input  logic                  stop_i,
  input  logic                  col_ready_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  col_valid_o,
  output logic                  col_last_o,
  output logic                  err_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full, dec_rsvd;
  logic             load, kill;
  logic [COL_W-1:0] st_base, st_idx, st_mask;
  logic             st_full, st_ilv;
  logic             err_q;

  bcg_len_decode #(.COL_W(COL_W)) dec_i (
    .code_i (len_code_i),
    .ilv_i  (ilv_i),
    .mask_o (dec_mask),
    .full_o (dec_full),
    .rsvd_o (dec_rsvd)
  );

  assign load = start_i && !dec_rsvd;
  assign kill = stop_i || (start_i && dec_rsvd);

  bcg_beat_ctr #(.COL_W(COL_W)) ctr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .kill_i   (kill),
    .take_i   (col_ready_i),
    .base_i   (start_col_i),
    .mask_i   (dec_mask),
    .full_i   (dec_full),
    .ilv_i    (ilv_i),
    .active_o (col_valid_o),
    .last_o   (col_last_o),
    .base_o   (st_base),
    .idx_o    (st_idx),
    .mask_o   (st_mask),
    .full_o   (st_full),
    .ilv_o    (st_ilv)
  );

  bcg_addr_map #(.COL_W(COL_W)) map_i (
    .base_i (st_base),
    .idx_i  (st_idx),
    .mask_i (st_mask),
    .ilv_i  (st_ilv),
    .col_o  (col_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= start_i && dec_rsvd;
  end
  assign err_o = err_q;

  // R5
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !col_valid_o);

  // R7
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !start_i |=> !col_valid_o);

  // R6
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !dec_rsvd |=> col_valid_o && (col_o == $past(start_col_i)));

  // R8
  row_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_full |-> !col_last_o);
endmodule

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] sc = '0;
  logic [2:0] code = '0;
  logic       il = 1'b0;
  logic       stop = 1'b0;
  logic       rdy = 1'b1;
  logic [7:0] col;
  logic       vld, lst, err;

  int vecs = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_col_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_col_i(sc),
    .len_code_i(code), .ilv_i(il), .stop_i(stop), .col_ready_i(rdy),
    .col_o(col), .col_valid_o(vld), .col_last_o(lst), .err_o(err)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_col(input logic [7:0] s, input int n,
                                         input int len, input bit x);
    logic [7:0] m;
    m = 8'(len - 1);
    if (x) return s ^ 8'(n);
    return (s & ~m) | (8'(int'(s) + n) & m);
  endfunction

  task automatic launch(input logic [7:0] s, input logic [2:0] c, input bit x);
    start = 1'b1; sc = s; code = c; il = x;
    step();
    start = 1'b0;
  endtask

  task automatic run_burst(input logic [7:0] s, input logic [2:0] c, input bit x);
    int len;
    len = 1 << c;
    launch(s, c, x);
    for (int n = 0; n < len; n++) begin
      chk("R1 valid", 32'(vld), 32'd1);
      chk(x ? "R3 interleaved col" : "R2 sequential col", 32'(col), 32'(exp_col(s, n, len, x)));
      chk("R8 last", 32'(lst), 32'(n == len - 1));
      step();
    end
    chk("R1 end of burst", 32'(vld), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 valid", 32'(vld), 32'd0);
    chk("R10 last", 32'(lst), 32'd0);
    chk("R10 err", 32'(err), 32'd0);
    rst_n = 1'b1;
    step();

    // R1 R2 R3 R8: all starts, lengths and orders
    for (int x = 0; x < 2; x++)
      for (int c = 0; c < 4; c++)
        for (int s = 0; s < 256; s++)
          run_burst(8'(s), 3'(c), bit'(x));

    // R4 full row across the 255->0 wrap, no last flag
    launch(8'd250, 3'b111, 1'b0);
    for (int n = 0; n < 300; n++) begin
      chk("R4 row col", 32'(col), 32'((250 + n) % 256));
      chk("R4 row valid", 32'(vld), 32'd1);
      chk("R8 row no last", 32'(lst), 32'd0);
      step();
    end
    stop = 1'b1; step(); stop = 1'b0;
    chk("R7 stop row", 32'(vld), 32'd0);

    // R5 reserved codes while idle
    for (int k = 0; k < 4; k++) begin
      launch(8'd9, (k < 3) ? 3'(4 + k) : 3'b111, (k == 3));
      chk("R5 err pulse", 32'(err), 32'd1);
      chk("R5 no beat", 32'(vld), 32'd0);
      step();
      chk("R5 err one cycle", 32'(err), 32'd0);
      chk("R5 still no beat", 32'(vld), 32'd0);
    end

    // R5 reserved code mid-burst ends it
    launch(8'd16, 3'b011, 1'b0);
    step();
    launch(8'd3, 3'b101, 1'b0);
    chk("R5 mid-burst err", 32'(err), 32'd1);
    chk("R5 mid-burst killed", 32'(vld), 32'd0);
    step();

    // R6 restart truncates the running burst
    launch(8'd2, 3'b011, 1'b0);
    step(); step();
    chk("R6 before restart", 32'(col), 32'd4);
    launch(8'h41, 3'b010, 1'b1);
    chk("R6 restart first", 32'(col), 32'h41);
    chk("R6 restart valid", 32'(vld), 32'd1);
    step();
    chk("R6 restart second", 32'(col), 32'h40);
    step(); step();
    chk("R6 restart last", 32'(lst), 32'd1);
    chk("R6 restart last col", 32'(col), 32'h42);
    step();
    chk("R6 restart end", 32'(vld), 32'd0);

    // R6 start wins over stop on the same cycle
    launch(8'd7, 3'b010, 1'b0);
    step();
    start = 1'b1; stop = 1'b1; sc = 8'd30; code = 3'b001; il = 1'b0;
    step();
    start = 1'b0; stop = 1'b0;
    chk("R6 start over stop valid", 32'(vld), 32'd1);
    chk("R6 start over stop col", 32'(col), 32'd30);
    step(); step();

    // R7 stop mid-burst
    launch(8'd32, 3'b011, 1'b0);
    step(); step();
    stop = 1'b1; step(); stop = 1'b0;
    chk("R7 stop mid", 32'(vld), 32'd0);
    step();
    chk("R7 stays idle", 32'(vld), 32'd0);

    // R9 back-pressure holds the beat
    launch(8'd5, 3'b010, 1'b0);
    rdy = 1'b0;
    for (int n = 0; n < 3; n++) begin
      step();
      chk("R9 hold col", 32'(col), 32'd5);
      chk("R9 hold valid", 32'(vld), 32'd1);
    end
    rdy = 1'b1; step();
    chk("R9 resume col", 32'(col), 32'd6);
    step(); step();
    rdy = 1'b0; step();
    chk("R9 hold last col", 32'(col), 32'd4);
    chk("R9 hold last", 32'(lst), 32'd1);
    rdy = 1'b1; step();
    chk("R9 end after release", 32'(vld), 32'd0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule